// File: doc/BRIEF.md
# Bus-Mapped Random Generator and Segment Register

This block hangs two small peripherals on the external data space of a microcontroller whose address and data share one bus. The top byte of the address, the data byte and the two active-low strobes (read and write) come in; the block decodes the top four address bits into windows. A write into the 0xF window lands in an eight-bit register that drives the segment lines. A write into the 0xC window seeds an eight-bit linear-feedback generator. A read of the 0xE window puts the generator's current value on the read-data byte and raises the bus-drive enable. When that read ends, the generator moves one step.

The strobes are asynchronous to the block clock. Each strobe passes through a synchronizer in the system-clock domain. The block acts once, on the rising (trailing) edge of the synchronized strobe. Address and data are captured while the synchronized strobe is low. The host must therefore hold them valid for the synchronizer depth (two cycles by default) after it releases the strobe. The effect of an access shows at the outputs by the third clock edge after the strobe rises.

Top module: `mmr_rng_display`

## Requirements
- R1: A write with address bits [7:4] equal to 0xF loads the data byte into the segment register, and `seg_out` shows it no later than the third clock edge after `wr_n` rises.
- R2: The segment register cannot be read: a read of the 0xF window keeps `bus_drive` low, keeps `rd_data` at 0x00 and leaves `seg_out` unchanged.
- R3: A write with address bits [7:4] equal to 0xC loads the data byte into the generator as its seed.
- R4: While `rd_n` is low and address bits [7:4] equal 0xE, `bus_drive` is high and `rd_data` carries the generator's current value.
- R5: Each completed read of the 0xE window advances the generator by exactly one step, however long the strobe is held. A step shifts the value left, and the new bit 0 is the XOR of old bits 7, 5, 4 and 3.
- R6: Seeded with 0x01, the generator visits 255 distinct values and returns 0x01 on the 256th read.
- R7: A write to the 0xE window, a read of the 0xC window and any access to another window leave the generator value unchanged.
- R8: A seed of 0x00 is accepted, and the generator then stays at 0x00 on every read.
- R9: While `rst_n` is low, `bus_drive` is low. After a reset, `seg_out` is 0x00 and the generator holds 0x00.
- R10: `bus_drive` is low and `rd_data` is 0x00 whenever `rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_hi | input | 8 | High byte of the bus address |
| bus_din | input | 8 | Data byte from the bus |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| seg_out | output | 8 | Segment register outputs |
| rd_data | output | 8 | Generator value for the bus, zero when not driving |
| bus_drive | output | 1 | High while the block must drive the bus |

## Verification
The bench holds a read strobe low for many clock cycles and then checks that the next read shows exactly one step. A design that acted on the level of the strobe rather than its edge would skip many states here. Reads of the segment window and writes into the generator window would show up either as a raised drive enable or as a disturbed generator sequence. A zero seed must stick at zero, and a tap error anywhere would break the full 255-step walk from 0x01 back to 0x01. A reset during activity must clear the segments and the generator and keep the bus driver off even with a read pending.

// File: rtl/mmr_pkg.sv
// Shared types and the window decode for the bus-mapped peripherals.
// Assumes windows are chosen by the top nibble of the high address byte.
package mmr_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SEED = 2'd1,
        WIN_GEN  = 2'd2,
        WIN_DISP = 2'd3
    } win_e;

    localparam logic [3:0] NIB_SEED = 4'hC;
    localparam logic [3:0] NIB_GEN  = 4'hE;
    localparam logic [3:0] NIB_DISP = 4'hF;

    // Map an address nibble to the peripheral window it selects.
    function automatic win_e decode_win(input logic [3:0] nib);
        case (nib)
            NIB_SEED: decode_win = WIN_SEED;
            NIB_GEN:  decode_win = WIN_GEN;
            NIB_DISP: decode_win = WIN_DISP;
            default:  decode_win = WIN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mmr_strobe_sync.sv
// Brings an asynchronous active-low strobe into the clock domain.
// Reports the synchronized low level and a one-cycle pulse on its release.
// Assumes the strobe idles high; reset presets the chain to idle.
module mmr_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic active,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Shift the raw strobe through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], strobe_n};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain[STAGES-1];
    end

    assign active = ~chain[STAGES-1];
    assign rise   = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/mmr_lfsr.sv
// Loadable Fibonacci shift register that steps left on request.
// The new bit 0 is the XOR of the tap-masked old value; load wins over step.
module mmr_lfsr #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic [W-1:0] q
);
    logic fb;

    // Feedback bit from the tapped positions.
    always_comb fb = ^(q & TAPS);

    // Load a seed or advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= seed;
        else if (step) q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/mmr_disp_reg.sv
// Write-only output register for the segment lines.
module mmr_disp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Capture the bus byte on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= din;
    end
endmodule

// File: rtl/mmr_rng_display.sv
// Top of the bus-mapped random generator and segment register.
// Strobes are synchronized, and address and data are captured while the
// synchronized strobe is low. Each access acts once, on the strobe's release.
// Assumes address and data remain valid STAGES cycles after the strobe rises.
module mmr_rng_display
    import mmr_pkg::*;
#(
    parameter int           DATA_W    = 8,
    parameter int           ADDR_HI_W = 8,
    parameter int           STAGES    = 2,
    parameter logic [7:0]   LFSR_TAPS = 8'hB8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic [DATA_W-1:0]    bus_din,
    input  logic                 rd_n,
    input  logic                 wr_n,
    output logic [DATA_W-1:0]    seg_out,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 bus_drive
);
    localparam int NSTB = 2;
    localparam int NIB_LO = ADDR_HI_W - 4;

    logic [NSTB-1:0]      stb_n, stb_active, stb_rise;
    logic                 rd_rise, wr_rise, any_active;
    logic [ADDR_HI_W-1:0] cap_addr;
    logic [DATA_W-1:0]    cap_data;
    win_e                 cap_win, live_win;
    logic                 seed_load, gen_step, disp_we;
    logic [DATA_W-1:0]    gen_q;

    assign stb_n = {wr_n, rd_n};

    genvar gi;
    generate
        for (gi = 0; gi < NSTB; gi++) begin : g_sync
            mmr_strobe_sync #(.STAGES(STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .strobe_n(stb_n[gi]),
                .active  (stb_active[gi]),
                .rise    (stb_rise[gi])
            );
        end
    endgenerate

    assign rd_rise    = stb_rise[0];
    assign wr_rise    = stb_rise[1];
    assign any_active = |stb_active;

    // Hold address and data sampled during the synchronized strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (any_active) begin
            cap_addr <= addr_hi;
            cap_data <= bus_din;
        end
    end

    // Decode the captured and the live address into windows.
    always_comb begin
        cap_win  = decode_win(cap_addr[ADDR_HI_W-1:NIB_LO]);
        live_win = decode_win(addr_hi[ADDR_HI_W-1:NIB_LO]);
    end

    // Qualify the strobe releases with their windows.
    always_comb begin
        seed_load = wr_rise && (cap_win == WIN_SEED);
        gen_step  = rd_rise && (cap_win == WIN_GEN);
        disp_we   = wr_rise && (cap_win == WIN_DISP);
    end

    mmr_lfsr #(.W(DATA_W), .TAPS(LFSR_TAPS[DATA_W-1:0])) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (seed_load),
        .step (gen_step),
        .seed (cap_data),
        .q    (gen_q)
    );

    mmr_disp_reg #(.W(DATA_W)) u_disp (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (disp_we),
        .din  (cap_data),
        .q    (seg_out)
    );

    // Drive the bus straight from the raw strobe so the data meets the host.
    always_comb begin
        bus_drive = rst_n && !rd_n && (live_win == WIN_GEN);
        rd_data   = bus_drive ? gen_q : '0;
    end
endmodule

// File: rtl/mmr_rng_display_chk.sv
// Property checker for mmr_rng_display, attached with a bind.
module mmr_rng_display_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              bus_drive,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] seg_out,
    input logic [DATA_W-1:0] gen_q,
    input logic              rd_rise,
    input logic              wr_rise,
    input logic              gen_step
);
    p_idle_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (!bus_drive && rd_data == '0));

    p_drive_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (rd_data == gen_q));

    p_gen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_rise && !wr_rise) |=> $stable(gen_q));

    p_gen_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_step && !wr_rise) |=> (gen_q == {$past(gen_q[DATA_W-2:0]),
            $past(gen_q[7] ^ gen_q[5] ^ gen_q[4] ^ gen_q[3])}));

    p_seg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rise |=> $stable(seg_out));

    p_zero_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q == '0 && !wr_rise) |=> (gen_q == '0));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (seg_out == '0 && gen_q == '0));
endmodule

bind mmr_rng_display mmr_rng_display_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_n     (rd_n),
    .bus_drive(bus_drive),
    .rd_data  (rd_data),
    .seg_out  (seg_out),
    .gen_q    (gen_q),
    .rd_rise  (rd_rise),
    .wr_rise  (wr_rise),
    .gen_step (gen_step)
);

// File: tb/mmr_rng_display_bench.sv
// Self-checking bench: a vector table, then directed corner cases.
module mmr_rng_display_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_hi = 8'h00;
    logic [7:0] bus_din = 8'h00;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] seg_out, rd_data;
    logic       bus_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mmr_rng_display u_mmr_rng_display (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .bus_din(bus_din),
        .rd_n(rd_n), .wr_n(wr_n), .seg_out(seg_out), .rd_data(rd_data),
        .bus_drive(bus_drive)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
        logic       drv;
        logic [7:0] rdat;
        logic [7:0] seg;
    } vec_t;

    // Accesses with the drive/read value seen mid-strobe and segments after.
    localparam vec_t TBL [12] = '{
        '{1'b1, 8'hF0, 8'hA5, 1'b0, 8'h00, 8'hA5},  // R1
        '{1'b1, 8'hC0, 8'h01, 1'b0, 8'h00, 8'hA5},  // R3
        '{1'b0, 8'hF1, 8'h00, 1'b0, 8'h00, 8'hA5},  // R2
        '{1'b0, 8'hE0, 8'h00, 1'b1, 8'h01, 8'hA5},  // R4
        '{1'b0, 8'hE7, 8'h00, 1'b1, 8'h02, 8'hA5},  // R5
        '{1'b1, 8'hE0, 8'hFF, 1'b0, 8'h00, 8'hA5},  // R7
        '{1'b0, 8'hE0, 8'h00, 1'b1, 8'h04, 8'hA5},  // R7
        '{1'b1, 8'h10, 8'h33, 1'b0, 8'h00, 8'hA5},  // R7
        '{1'b0, 8'hC0, 8'h00, 1'b0, 8'h00, 8'hA5},  // R7
        '{1'b0, 8'hEF, 8'h00, 1'b1, 8'h08, 8'hA5},  // R5
        '{1'b1, 8'hFF, 8'h3C, 1'b0, 8'h00, 8'h3C},  // R1
        '{1'b0, 8'hE0, 8'h00, 1'b1, 8'h11, 8'h3C}   // R5
    };

    function automatic logic [7:0] model_next(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    logic [7:0] mid_data;
    logic       mid_drive;

    // One bus access; samples drive and data mid-strobe, then settles.
    task automatic access(input bit wr, input logic [7:0] a,
                          input logic [7:0] d, input int hold);
        @(negedge clk);
        addr_hi = a;
        bus_din = d;
        @(negedge clk);
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        mid_data  = rd_data;
        mid_drive = bus_drive;
        wr_n = 1'b1;
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_v;
        int         seed_hits;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(seg_out == 8'h00, "R9 seg after reset", seg_out, 8'h00);
        check(!bus_drive, "R9 drive after reset", {7'd0, bus_drive}, 8'h00);
        check(rd_data == 8'h00, "R10 idle rd_data", rd_data, 8'h00);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            access(TBL[i].wr, TBL[i].addr, TBL[i].data, 8);
            if (!TBL[i].wr) begin
                check(mid_drive == TBL[i].drv, "R4/R2 table drive",
                      {7'd0, mid_drive}, {7'd0, TBL[i].drv});
                check(mid_data == TBL[i].rdat, "R4/R5 table read",
                      mid_data, TBL[i].rdat);
            end
            check(seg_out == TBL[i].seg, "R1/R2 table seg", seg_out, TBL[i].seg);
            check(!bus_drive && rd_data == 8'h00, "R10 drive after read",
                  rd_data, 8'h00);
        end

        // R5: long strobe gives one step only
        access(1'b1, 8'hC3, 8'h08, 8);
        access(1'b0, 8'hE0, 8'h00, 30);
        check(mid_data == 8'h08, "R3 seed readback", mid_data, 8'h08);
        access(1'b0, 8'hE0, 8'h00, 3);
        check(mid_data == 8'h11, "R5 single step after long strobe", mid_data, 8'h11);

        // R6: full period from 0x01
        access(1'b1, 8'hC0, 8'h01, 4);
        exp_v = 8'h01;
        seed_hits = 0;
        for (int k = 0; k < 255; k++) begin
            access(1'b0, 8'hE0, 8'h00, 3);
            if (mid_data == 8'h01) seed_hits++;
            check(mid_data == exp_v, "R6 sequence", mid_data, exp_v);
            exp_v = model_next(exp_v);
        end
        check(seed_hits == 1, "R6 seed seen once in period",
              seed_hits[7:0], 8'h01);
        access(1'b0, 8'hE0, 8'h00, 3);
        check(mid_data == 8'h01, "R6 return to seed", mid_data, 8'h01);

        // R8: zero seed locks
        access(1'b1, 8'hC0, 8'h00, 4);
        for (int k = 0; k < 3; k++) begin
            access(1'b0, 8'hE0, 8'h00, 4);
            check(mid_data == 8'h00 && mid_drive, "R8 zero lock", mid_data, 8'h00);
        end

        // R9: reset during activity
        access(1'b1, 8'hF0, 8'h5A, 4);
        access(1'b1, 8'hC0, 8'h55, 4);
        @(negedge clk);
        rst_n = 1'b0;
        addr_hi = 8'hE0;
        rd_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!bus_drive, "R9 no drive in reset", {7'd0, bus_drive}, 8'h00);
        check(seg_out == 8'h00, "R9 seg cleared", seg_out, 8'h00);
        rd_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        access(1'b0, 8'hE0, 8'h00, 4);
        check(mid_data == 8'h00, "R9 generator cleared", mid_data, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule